// File: doc/BRIEF.md
# Link Width and Lane Reversal Resolver

This block settles how many lanes of an up-to-eight-lane serial link carry traffic and which physical lane serves each logical lane. Software or board strapping supplies a lane-disable mask. The receive side reports two per-lane vectors: one says which physical lanes have finished training, the other says on which physical lane the link partner's lane 0 was seen. From these, on each resolve strobe, the block chooses a width of x8, x4, x2 or x1, decides between normal and reversed lane order, and publishes a per-logical-lane physical index.

The maximum width that the mask permits is also reported as a 6-bit value for a capability register. The chosen width depends on that maximum and on the previous result: a reversed x8 link may fall back only to x1. The block keeps its result until the next strobe and never changes width on its own. It has no streaming data path, so every pin is a plain level-sampled control or status signal.

Top module: `link_width_resolver`

## Requirements
- R1: After reset, width_out is 0, link_down is 1, reversed is 0, max_width_cap is 8 and lane_map is the identity map.
- R2: Bit X of disable_mask set disables physical lane X. On a resolve, max_width_cap takes the largest W in {8,4,2,1} whose lanes 0..W-1 are all enabled, as a plain binary number (0x00 gives 8, 0xF0 gives 4, 0xFC gives 2, 0xFE gives 1), or 0 when lane 0 is disabled.
- R3: With a maximum of 8 any width of 8, 4, 2 or 1 may be chosen; with a maximum of 4 only 4 or 1; with a maximum of 2 only 2 or 1; with a maximum of 1 only 1.
- R4: A width W qualifies in normal order when physical lanes 0..W-1 are all enabled and trained and lane_zero_hit[0] is set, and in reversed order when the same lanes are ready and lane_zero_hit[W-1] is set. The widest permitted qualifying width is chosen, and normal order wins when both orders qualify.
- R5: Reversed order is only ever chosen at width 8 or 4; reversed is 1 only with those widths.
- R6: When the result in force is reversed x8 and the maximum is 8, the next resolve may choose only 8 or 1 (x4 and x2 are skipped), or report link down.
- R7: lane_map bits [3i+2:3i] hold the physical lane of logical lane i. In normal order it is i; in reversed order it is W-1-i for i below W and i for the rest.
- R8: When no permitted width qualifies, link_down is 1, width_out is 0, reversed is 0 and lane_map is the identity map.
- R9: Outputs change only at the clock edge where resolve is high, and show the new result from the cycle after that edge; input changes without a strobe have no effect.
- R10: width_out is a 4-bit binary lane count: 8, 4, 2, 1, or 0 when the link is down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disable_mask | input | 8 | Per-lane disable, bit X disables lane X |
| lane_trained | input | 8 | Per-lane training complete |
| lane_zero_hit | input | 8 | Partner lane 0 observed on this physical lane |
| resolve | input | 1 | One-cycle strobe to re-resolve the link |
| width_out | output | 4 | Negotiated lane count, 0 when down |
| reversed | output | 1 | Reversed lane order in effect |
| link_down | output | 1 | No permitted width qualified |
| lane_map | output | 24 | 3-bit physical index per logical lane |
| max_width_cap | output | 6 | Maximum width allowed by the mask |

## Verification
A corrupted stored result shows at the ports in the very next cycle, because width, order and lane map are all driven straight from the result register. The most delicate state is the memory of a reversed x8 result, which only changes the outcome of the following resolve: a wrong value there appears one strobe later as an x4 or x2 choice where only x1 is legal, so the bench chains vectors so that each such state is consumed by the next row. Permitted-set and preference errors surface as a wrong width or order one cycle after the strobe that exposes them.

// File: rtl/lwr_pkg.sv
package lwr_pkg;
  // Lane order picked for a candidate width.
  typedef enum logic [1:0] {
    ORD_NONE     = 2'd0,
    ORD_NORMAL   = 2'd1,
    ORD_REVERSED = 2'd2
  } lwr_order_e;

  // Number of width candidates for a lane count that is a power of two.
  function automatic int num_widths(input int lanes);
    return $clog2(lanes) + 1;
  endfunction
endpackage

// File: rtl/lwr_cap_decode.sv
module lwr_cap_decode #(
  parameter int NUM_LANES = 8,
  parameter int CAP_W     = 6
) (
  input  logic [NUM_LANES-1:0] disable_mask,
  output logic [CAP_W-1:0]     max_cap
);
  localparam int NUM_W = lwr_pkg::num_widths(NUM_LANES);

  logic [NUM_W-1:0] span_ok;

  // Candidate k spans lanes 0 .. (NUM_LANES>>k)-1.
  for (genvar k = 0; k < NUM_W; k++) begin : g_span
    localparam int W = NUM_LANES >> k;
    assign span_ok[k] = ~|disable_mask[W-1:0];
  end

  always_comb begin
    max_cap = '0;
    // Narrowest first so the widest passing span wins.
    for (int k = NUM_W - 1; k >= 0; k--) begin
      if (span_ok[k]) max_cap = CAP_W'(NUM_LANES >> k);
    end
  end
endmodule

// File: rtl/lwr_qualifier.sv
module lwr_qualifier #(
  parameter int NUM_LANES  = 8,
  parameter int REV_LEVELS = 2
) (
  input  logic [NUM_LANES-1:0]                       disable_mask,
  input  logic [NUM_LANES-1:0]                       lane_trained,
  input  logic [NUM_LANES-1:0]                       lane_zero_hit,
  output logic [lwr_pkg::num_widths(NUM_LANES)-1:0]  norm_ok,
  output logic [lwr_pkg::num_widths(NUM_LANES)-1:0]  rev_ok
);
  localparam int NUM_W = lwr_pkg::num_widths(NUM_LANES);

  logic [NUM_LANES-1:0] lane_ready;
  assign lane_ready = lane_trained & ~disable_mask;

  for (genvar k = 0; k < NUM_W; k++) begin : g_cand
    localparam int W = NUM_LANES >> k;
    logic span_ready;
    assign span_ready = &lane_ready[W-1:0];
    assign norm_ok[k] = span_ready & lane_zero_hit[0];
    if (k < REV_LEVELS && W > 1) begin : g_rev
      assign rev_ok[k] = span_ready & lane_zero_hit[W-1];
    end else begin : g_norev
      assign rev_ok[k] = 1'b0;
    end
  end
endmodule

// File: rtl/lwr_select.sv
module lwr_select #(
  parameter int NUM_LANES = 8,
  parameter int CAP_W     = 6,
  parameter int WID_W     = 4
) (
  input  logic [CAP_W-1:0]                          max_cap,
  input  logic [lwr_pkg::num_widths(NUM_LANES)-1:0] norm_ok,
  input  logic [lwr_pkg::num_widths(NUM_LANES)-1:0] rev_ok,
  input  logic                                      prev_rev_full,
  output logic [WID_W-1:0]                          sel_width,
  output logic                                      sel_rev,
  output logic                                      sel_down
);
  import lwr_pkg::*;
  localparam int NUM_W = num_widths(NUM_LANES);

  logic [NUM_W-1:0] allow;
  logic             max_full;
  lwr_order_e       order;

  assign max_full = (max_cap == CAP_W'(NUM_LANES));

  // Permitted widths for each candidate.
  for (genvar k = 0; k < NUM_W; k++) begin : g_allow
    localparam int W = NUM_LANES >> k;
    if (k == 0) begin : g_full
      assign allow[k] = max_full;
    end else if (W == 1) begin : g_one
      assign allow[k] = (max_cap != '0);
    end else begin : g_mid
      // Full maximum: every narrower width unless a reversed full-width
      // result is in force. Reduced maximum: only the maximum itself.
      assign allow[k] = max_full ? ~prev_rev_full : (max_cap == CAP_W'(W));
    end
  end

  always_comb begin
    sel_width = '0;
    order     = ORD_NONE;
    for (int k = 0; k < NUM_W; k++) begin
      if (order == ORD_NONE && allow[k]) begin
        if (norm_ok[k]) begin
          order     = ORD_NORMAL;
          sel_width = WID_W'(NUM_LANES >> k);
        end else if (rev_ok[k]) begin
          order     = ORD_REVERSED;
          sel_width = WID_W'(NUM_LANES >> k);
        end
      end
    end
    sel_rev  = (order == ORD_REVERSED);
    sel_down = (order == ORD_NONE);
  end
endmodule

// File: rtl/lwr_lane_map.sv
module lwr_lane_map #(
  parameter int NUM_LANES = 8,
  parameter int IDX_W     = 3,
  parameter int WID_W     = 4
) (
  input  logic [WID_W-1:0]           width,
  input  logic                       rev,
  output logic [NUM_LANES*IDX_W-1:0] lane_map
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [WID_W-1:0] mirrored;
    logic             in_span;
    assign mirrored = width - WID_W'(1) - WID_W'(i);
    assign in_span  = (WID_W'(i) < width);
    assign lane_map[i*IDX_W +: IDX_W] =
      (rev && in_span) ? mirrored[IDX_W-1:0] : IDX_W'(i);
  end
endmodule

// File: rtl/link_width_resolver.sv
module link_width_resolver #(
  parameter int NUM_LANES = 8,
  parameter int CAP_W     = 6,
  parameter int REV_LEVELS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LANES-1:0]   disable_mask,
  input  logic [NUM_LANES-1:0]   lane_trained,
  input  logic [NUM_LANES-1:0]   lane_zero_hit,
  input  logic                   resolve,
  output logic [$clog2(NUM_LANES):0]           width_out,
  output logic                   reversed,
  output logic                   link_down,
  output logic [NUM_LANES*$clog2(NUM_LANES)-1:0] lane_map,
  output logic [CAP_W-1:0]       max_width_cap
);
  localparam int IDX_W = $clog2(NUM_LANES);
  localparam int WID_W = IDX_W + 1;
  localparam int NUM_W = lwr_pkg::num_widths(NUM_LANES);

  logic [CAP_W-1:0] cap_next;
  logic [NUM_W-1:0] norm_ok, rev_ok;
  logic [WID_W-1:0] sel_width;
  logic             sel_rev, sel_down;

  logic [WID_W-1:0] width_q;
  logic             rev_q, down_q;
  logic [CAP_W-1:0] cap_q;
  logic             prev_rev_full;

  lwr_cap_decode #(.NUM_LANES(NUM_LANES), .CAP_W(CAP_W)) u_cap (
    .disable_mask (disable_mask),
    .max_cap      (cap_next)
  );

  lwr_qualifier #(.NUM_LANES(NUM_LANES), .REV_LEVELS(REV_LEVELS)) u_qual (
    .disable_mask  (disable_mask),
    .lane_trained  (lane_trained),
    .lane_zero_hit (lane_zero_hit),
    .norm_ok       (norm_ok),
    .rev_ok        (rev_ok)
  );

  assign prev_rev_full = rev_q && (width_q == WID_W'(NUM_LANES));

  lwr_select #(.NUM_LANES(NUM_LANES), .CAP_W(CAP_W), .WID_W(WID_W)) u_sel (
    .max_cap       (cap_next),
    .norm_ok       (norm_ok),
    .rev_ok        (rev_ok),
    .prev_rev_full (prev_rev_full),
    .sel_width     (sel_width),
    .sel_rev       (sel_rev),
    .sel_down      (sel_down)
  );

  // Result register: loaded only on a resolve strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= '0;
      rev_q   <= 1'b0;
      down_q  <= 1'b1;
      cap_q   <= CAP_W'(NUM_LANES);
    end else if (resolve) begin
      width_q <= sel_width;
      rev_q   <= sel_rev;
      down_q  <= sel_down;
      cap_q   <= cap_next;
    end
  end

  lwr_lane_map #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W), .WID_W(WID_W)) u_map (
    .width    (width_q),
    .rev      (rev_q),
    .lane_map (lane_map)
  );

  assign width_out     = width_q;
  assign reversed      = rev_q;
  assign link_down     = down_q;
  assign max_width_cap = cap_q;
endmodule

// File: rtl/lwr_checker.sv
module lwr_checker #(
  parameter int NUM_LANES = 8,
  parameter int CAP_W     = 6
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   resolve,
  input logic [$clog2(NUM_LANES):0]             width_out,
  input logic                                   reversed,
  input logic                                   link_down,
  input logic [NUM_LANES*$clog2(NUM_LANES)-1:0] lane_map,
  input logic [CAP_W-1:0]                       max_width_cap
);
  localparam int WID_W = $clog2(NUM_LANES) + 1;

  AST_HOLD_WITHOUT_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> ($stable(width_out) && $stable(reversed) && $stable(link_down) && $stable(lane_map) && $stable(max_width_cap))); // R9

  AST_DOWN_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    link_down |-> (width_out == '0 && !reversed)); // R8

  AST_REV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    reversed |-> (width_out == WID_W'(NUM_LANES) || width_out == WID_W'(NUM_LANES/2))); // R5

  AST_WIDTH_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(width_out) <= 1); // R10

  AST_REV_FULL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && reversed && width_out == WID_W'(NUM_LANES) && max_width_cap == CAP_W'(NUM_LANES))
      |=> (width_out == WID_W'(NUM_LANES) || width_out == WID_W'(1) || width_out == '0)); // R6

  AST_WIDTH_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !link_down |-> ({{(CAP_W){1'b0}}, width_out} <= {{(WID_W){1'b0}}, max_width_cap})); // R3
endmodule

bind link_width_resolver lwr_checker #(.NUM_LANES(NUM_LANES), .CAP_W(CAP_W)) u_lwr_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .resolve       (resolve),
  .width_out     (width_out),
  .reversed      (reversed),
  .link_down     (link_down),
  .lane_map      (lane_map),
  .max_width_cap (max_width_cap)
);

// File: tb/test_link_width_resolver.sv
`timescale 1ns/1ps
module test_link_width_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  disable_mask = '0;
  logic [7:0]  lane_trained = '0;
  logic [7:0]  lane_zero_hit = '0;
  logic        resolve = 1'b0;
  logic [3:0]  width_out;
  logic        reversed;
  logic        link_down;
  logic [23:0] lane_map;
  logic [5:0]  max_width_cap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_width_resolver i_link_width_resolver (
    .clk, .rst_n, .disable_mask, .lane_trained, .lane_zero_hit, .resolve,
    .width_out, .reversed, .link_down, .lane_map, .max_width_cap
  );

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] trained;
    logic [7:0] hit;
    logic [3:0] w;
    logic       rev;
    logic       down;
    logic [5:0] cap;
  } vec_t;

  // Rows are applied in order; some rows rely on the result of the one before.
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'hFF, 8'h01, 4'd8, 1'b0, 1'b0, 6'd8}, // R4 normal x8
    '{8'h00, 8'hFF, 8'h80, 4'd8, 1'b1, 1'b0, 6'd8}, // R4 reversed x8
    '{8'h00, 8'h0F, 8'h09, 4'd1, 1'b0, 1'b0, 6'd8}, // R6 x4 skipped after reversed x8
    '{8'h00, 8'h0F, 8'h09, 4'd4, 1'b0, 1'b0, 6'd8}, // R3 x4 allowed again
    '{8'h00, 8'h0F, 8'h08, 4'd4, 1'b1, 1'b0, 6'd8}, // R5 reversed x4
    '{8'hF0, 8'hFF, 8'h01, 4'd4, 1'b0, 1'b0, 6'd4}, // R2 mask F0
    '{8'hF0, 8'h03, 8'h01, 4'd1, 1'b0, 1'b0, 6'd4}, // R3 max4 never x2
    '{8'h00, 8'h03, 8'h01, 4'd2, 1'b0, 1'b0, 6'd8}, // R3 max8 allows x2
    '{8'hFC, 8'hFF, 8'h01, 4'd2, 1'b0, 1'b0, 6'd2}, // R2 mask FC
    '{8'hFC, 8'hFF, 8'h02, 4'd0, 1'b0, 1'b1, 6'd2}, // R5 no reversal at x2 -> R8 down
    '{8'hFE, 8'hFF, 8'h01, 4'd1, 1'b0, 1'b0, 6'd1}, // R2 mask FE
    '{8'h01, 8'hFF, 8'h01, 4'd0, 1'b0, 1'b1, 6'd0}, // R2 lane0 disabled, R8
    '{8'h00, 8'hFF, 8'h81, 4'd8, 1'b0, 1'b0, 6'd8}, // R4 normal preferred
    '{8'h00, 8'h7F, 8'h01, 4'd4, 1'b0, 1'b0, 6'd8}, // R4 widest fails, x4 next
    '{8'h10, 8'hFF, 8'h01, 4'd4, 1'b0, 1'b0, 6'd4}  // R2 lane4 disabled
  };

  function automatic logic [23:0] exp_map(input int w, input bit rev);
    logic [23:0] m;
    for (int i = 0; i < 8; i++) begin
      int p;
      p = (rev && i < w) ? (w - 1 - i) : i;
      m[3*i +: 3] = 3'(p);
    end
    return m;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] m, input logic [7:0] t, input logic [7:0] h);
    @(negedge clk);
    disable_mask = m; lane_trained = t; lane_zero_hit = h; resolve = 1'b1;
    @(negedge clk);
    resolve = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "width", width_out, 0);
    check("R1", "link_down", link_down, 1);
    check("R1", "reversed", reversed, 0);
    check("R1", "cap", max_width_cap, 8);
    check("R1", "map", lane_map, exp_map(0, 1'b0));

    // Table walk (R2..R8, R10)
    for (int r = 0; r < NV; r++) begin
      apply(VECS[r].mask, VECS[r].trained, VECS[r].hit);
      check("R4/R10", $sformatf("row%0d width", r), width_out, VECS[r].w);
      check("R5", $sformatf("row%0d reversed", r), reversed, VECS[r].rev);
      check("R8", $sformatf("row%0d link_down", r), link_down, VECS[r].down);
      check("R2", $sformatf("row%0d cap", r), max_width_cap, VECS[r].cap);
      check("R7", $sformatf("row%0d map", r), lane_map, exp_map(VECS[r].w, VECS[r].rev));
    end

    // R9: inputs change without a strobe, result held
    @(negedge clk);
    disable_mask = 8'hFE; lane_trained = 8'h00; lane_zero_hit = 8'h80;
    repeat (4) @(negedge clk);
    check("R9", "width held", width_out, 4);
    check("R9", "cap held", max_width_cap, 4);
    check("R9", "down held", link_down, 0);

    // R7 reversed x8 map explicitly: logical i -> 7-i
    apply(8'h00, 8'hFF, 8'h80);
    check("R7", "rev8 map", lane_map, 24'({3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}));
    // R6 reversed x8 with only lanes 0..1 ready -> x1, not x2
    apply(8'h00, 8'h03, 8'h01);
    check("R6", "rev8 fallback width", width_out, 1);
    // R8 down map identity after reversed state
    apply(8'h00, 8'hFF, 8'h80);
    apply(8'h00, 8'hFE, 8'h80);
    check("R8", "down width", width_out, 0);
    check("R8", "down map", lane_map, exp_map(0, 1'b0));

    // R1 reset again restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset cap", max_width_cap, 8);
    check("R1", "reset down", link_down, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule